// File: doc/BRIEF.md
# Tile-Buffered 3x3 Mean Filter

This block takes a square patch of signed samples (16 rows by 16 columns by default) over a valid/ready input stream in row-major order, holds the whole patch in a local tile buffer, and only then replaces every sample with the mean of the 3x3 neighbourhood centred on it. Samples beyond the patch edge count as zero while the divisor stays nine. The mean is the exact quotient truncated toward zero.

All window sums read the samples as loaded. Each result goes to a second bank at the same row and column. Once every position has been computed, that bank replaces the tile in a single cycle. The filtered patch then leaves over a valid/ready output stream in row-major order, with a flag on the final element. One patch is handled at a time. A busy flag covers the span from the first accepted sample to the final output handshake.

Top module: `tile_avg3x3`

## Requirements
- R1: Out of reset, inReady is 1 and outValid and busy are 0.
- R2: While loading, inReady stays 1. A sample is taken on every cycle with inValid and inReady both high. The k-th accepted sample (k from 0) is stored at row k / COLS and column k % COLS.
- R3: No result appears until all ROWS*COLS samples have been taken. outValid stays 0 during the load, including across gaps in inValid, and is never high together with inReady.
- R4: Each output equals the sum of the 3x3 window around its position, divided by 9. The window uses the loaded input values only, never results already computed.
- R5: Window positions outside the tile contribute 0, and the divisor is still 9. For a constant tile of value v, a corner gives trunc(4v/9), a non-corner edge gives trunc(6v/9) and an interior position gives v.
- R6: Outputs leave in row-major order, one on each cycle with outValid and outReady both high. While outValid is high and outReady is low, outData and outLast stay unchanged.
- R7: outLast is 1 only with the final (ROWS*COLS-th) output and only while outValid is 1.
- R8: busy rises in the cycle after the first sample is accepted and stays 1 until the handshake of the final output. While busy is 1 and the tile is full, inReady is 0. When busy is 0, inReady is 1.
- R9: After a patch has left, the next patch is accepted and filtered with no trace of the previous one.
- R10: inData and outData are two's complement. A negative window sum gives a quotient truncated toward zero, for example -10 gives -1 and -8 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample present |
| inReady | output | 1 | Block takes a sample this cycle |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | Filtered sample present |
| outReady | input | 1 | Consumer takes the output this cycle |
| outData | output | DATA_W | Signed filtered sample |
| outLast | output | 1 | Final sample of the patch |
| busy | output | 1 | A patch is in progress |

## Verification
A constant tile makes corners, edges and the interior give three distinct known values, so errors in border handling or divisor show up by position. A signed ramp-like pattern with negative values makes every window different. It separates correct row/column addressing and truncation toward zero from floor rounding, and it would expose any read of an already-written result. A checkerboard of the most positive and most negative values stresses the sum width and the reciprocal divide at full range. The same run uses a stalled load and irregular output backpressure to test the barrier and the output ordering.

// File: rtl/tile_avg_pkg.sv
package tile_avg_pkg;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_CALC,
    PH_SWAP,
    PH_SEND
  } phase_e;

  typedef struct packed {
    logic loadWr;     // store the incoming sample at the current position
    logic calcWr;     // store the window mean into the result bank
    logic swapBanks;  // copy the whole result bank over the tile
  } ctrl_strobe_t;

endpackage

// File: rtl/tile_avg_ctrl.sv
module tile_avg_ctrl
  import tile_avg_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int RW   = 4,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output ctrl_strobe_t  strobe,
  output logic [RW-1:0] rowIdx,
  output logic [CW-1:0] colIdx,
  output logic          inReady,
  output logic          outValid,
  output logic          outLast,
  output logic          busy
);

  phase_e phase;
  logic   lastPos;
  logic   step;
  logic   lastCol;

  always_comb begin
    lastCol          = (colIdx == CW'(COLS - 1));
    lastPos          = lastCol && (rowIdx == RW'(ROWS - 1));
    inReady          = (phase == PH_LOAD);
    outValid         = (phase == PH_SEND);
    outLast          = outValid && lastPos;
    strobe.loadWr    = inReady && inValid;
    strobe.calcWr    = (phase == PH_CALC);
    strobe.swapBanks = (phase == PH_SWAP);
    step             = strobe.loadWr || strobe.calcWr || (outValid && outReady);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_LOAD;
      rowIdx <= '0;
      colIdx <= '0;
      busy   <= 1'b0;
    end else begin
      if (step) begin
        if (lastPos) begin
          rowIdx <= '0;
          colIdx <= '0;
        end else if (lastCol) begin
          colIdx <= '0;
          rowIdx <= rowIdx + 1'b1;
        end else begin
          colIdx <= colIdx + 1'b1;
        end
      end

      unique case (phase)
        PH_LOAD: if (strobe.loadWr && lastPos) phase <= PH_CALC;
        PH_CALC: if (lastPos) phase <= PH_SWAP;
        PH_SWAP: phase <= PH_SEND;
        PH_SEND: if (outReady && lastPos) phase <= PH_LOAD;
        default: phase <= PH_LOAD;
      endcase

      if (strobe.loadWr) busy <= 1'b1;
      if (outValid && outReady && lastPos) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/tile_avg_dp.sv
module tile_avg_dp
  import tile_avg_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int DATA_W = 12,
  parameter int RW     = 4,
  parameter int CW     = 4
) (
  input  logic                     clk,
  input  ctrl_strobe_t             strobe,
  input  logic [RW-1:0]            rowIdx,
  input  logic [CW-1:0]            colIdx,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] outData
);

  localparam int    NUM    = ROWS * COLS;
  localparam int    IDX_W  = $clog2(NUM);
  localparam int    SUM_W  = DATA_W + 4;
  localparam int    SHIFT  = SUM_W + 4;
  localparam int    PROD_W = SHIFT + DATA_W;
  localparam longint RECIP = ((longint'(1) << SHIFT) + 8) / 9;

  logic signed [DATA_W-1:0] tile    [NUM];
  logic signed [DATA_W-1:0] resBank [NUM];
  logic signed [DATA_W-1:0] tapVal  [9];
  logic [IDX_W-1:0]         linAddr;
  logic signed [SUM_W-1:0]  winSum;
  logic [SUM_W-1:0]         sumMag;
  logic [PROD_W-1:0]        prod;
  logic [DATA_W-1:0]        quot;
  logic signed [DATA_W-1:0] mean;

  assign linAddr = IDX_W'(rowIdx) * IDX_W'(COLS) + IDX_W'(colIdx);

  // Nine neighbour taps; positions beyond the tile read as zero.
  for (genvar t = 0; t < 9; t++) begin : g_tap
    localparam int DR = t / 3 - 1;
    localparam int DC = t % 3 - 1;
    int nr;
    int nc;
    always_comb begin
      nr = int'(rowIdx) + DR;
      nc = int'(colIdx) + DC;
      if (nr >= 0 && nr < ROWS && nc >= 0 && nc < COLS)
        tapVal[t] = tile[IDX_W'(nr * COLS + nc)];
      else
        tapVal[t] = '0;
    end
  end

  // Window sum, then divide by nine via reciprocal multiply on the magnitude.
  always_comb begin
    winSum = '0;
    for (int t = 0; t < 9; t++)
      winSum = winSum + {{(SUM_W - DATA_W){tapVal[t][DATA_W-1]}}, tapVal[t]};
    sumMag = winSum[SUM_W-1] ? SUM_W'(-winSum) : SUM_W'(winSum);
    prod   = PROD_W'(sumMag) * PROD_W'(RECIP);
    quot   = prod[SHIFT +: DATA_W];
    mean   = winSum[SUM_W-1] ? -$signed(quot) : $signed(quot);
  end

  always_ff @(posedge clk) begin
    if (strobe.loadWr) tile[linAddr] <= inData;
    if (strobe.swapBanks)
      for (int i = 0; i < NUM; i++) tile[i] <= resBank[i];
    if (strobe.calcWr) resBank[linAddr] <= mean;
  end

  assign outData = tile[linAddr];

endmodule

// File: rtl/tile_avg3x3.sv
module tile_avg3x3
  import tile_avg_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] outData,
  output logic                     outLast,
  output logic                     busy
);

  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  ctrl_strobe_t  strobe;
  logic [RW-1:0] rowIdx;
  logic [CW-1:0] colIdx;

  tile_avg_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .strobe   (strobe),
    .rowIdx   (rowIdx),
    .colIdx   (colIdx),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .busy     (busy)
  );

  tile_avg_dp #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .RW(RW), .CW(CW)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .rowIdx  (rowIdx),
    .colIdx  (colIdx),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/tile_avg3x3_chk.sv
module tile_avg3x3_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outLast,
  input logic              busy
);

  // R3: input and output phases never overlap
  a_r3_no_out_in_load: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);

  // R6: a stalled output holds its value
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R7: the final flag only accompanies valid data
  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8: output activity implies busy
  a_r8_busy_on_out: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R8: when idle, input is open
  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> inReady);

  // R8: an accepted sample leaves busy set
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy);

endmodule

bind tile_avg3x3 tile_avg3x3_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast),
  .busy     (busy)
);

// File: tb/tile_avg3x3_tb.sv
`timescale 1ns/1ps
module tile_avg3x3_tb;

  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int DW   = 12;
  localparam int NUM  = ROWS * COLS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inReady;
  logic signed [DW-1:0] inData = '0;
  logic                 outValid;
  logic                 outReady = 1'b1;
  logic signed [DW-1:0] outData;
  logic                 outLast;
  logic                 busy;

  tile_avg3x3 #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .busy(busy)
  );

  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  int          img [NUM];
  logic [DW:0] expQ [$];
  string       curTag = "R4";
  int          readyMode = 0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int px(input int r, input int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return img[r * COLS + c];
  endfunction

  task automatic push_expected();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int s = 0;
        int m;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++) s += px(r + dr, c + dc);
        m = s / 9;  // truncates toward zero
        expQ.push_back({(r == ROWS - 1 && c == COLS - 1), DW'(m)});
      end
  endtask

  // Output pacing, changed at the rising edge so it is stable at the falling edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (readyMode)
      1:       outReady <= (cyc % 3) != 0;
      2:       outReady <= (cyc % 7) < 2;
      default: outReady <= 1'b1;
    endcase
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 output with nothing expected", int'(outData), 0);
      end else begin
        logic [DW:0] e;
        e = expQ.pop_front();
        chk(outData == e[DW-1:0], {curTag, " R2 R4 R6 data"}, int'(outData),
            int'($signed(e[DW-1:0])));
        chk(outLast == e[DW], "R7 last flag", int'(outLast), int'(e[DW]));
      end
    end
  end

  task automatic drive_tile(input int stallAt);
    push_expected();
    @(negedge clk);
    chk(busy == 1'b0 && inReady == 1'b1, "R9 idle before patch", int'(busy), 0);
    for (int i = 0; i < NUM; i++) begin
      if (i == stallAt) begin
        inValid = 1'b0;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          chk(outValid == 1'b0, "R3 no output during stalled load", int'(outValid), 0);
        end
        chk(busy == 1'b1 && inReady == 1'b1, "R2 R8 ready and busy mid-load",
            int'(inReady), 1);
      end
      inValid = 1'b1;
      inData  = DW'(img[i]);
      while (!inReady) @(negedge clk);
      @(negedge clk);
      if (i == 0) chk(busy == 1'b1, "R8 busy after first take", int'(busy), 1);
    end
    inValid = 1'b0;
    chk(inReady == 1'b0, "R8 input closed once tile full", int'(inReady), 0);
    chk(outValid == 1'b0, "R3 no output right after load", int'(outValid), 0);
    while (busy) @(negedge clk);
    chk(expQ.size() == 0, "R6 all positions emitted", expQ.size(), 0);
    chk(inReady == 1'b1 && outValid == 1'b0, "R8 R9 idle after patch", int'(inReady), 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // Constant tile: corner 4, edge 6, interior 9.
    curTag = "R5";
    for (int i = 0; i < NUM; i++) img[i] = 9;
    readyMode = 0;
    drive_tile(100);

    // Signed varied tile with negatives, light backpressure.
    curTag = "R10";
    for (int i = 0; i < NUM; i++) img[i] = ((i * 37 + (i / COLS) * 11) % 200) - 100;
    readyMode = 1;
    drive_tile(-1);

    // Full-range checkerboard, heavy backpressure.
    curTag = "R4";
    for (int i = 0; i < NUM; i++)
      img[i] = (((i / COLS) + (i % COLS)) % 2 == 0) ? 2047 : -2048;
    readyMode = 2;
    drive_tile(7);

    // Next patch after a full-range one: fresh, independent result.
    curTag = "R9";
    for (int i = 0; i < NUM; i++) img[i] = (i % 5) - 2 + ((i / COLS) % 3) * 50;
    readyMode = 0;
    drive_tile(-1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule